// File: doc/BRIEF.md
# Four-Channel DAC Serial Register Interface

This block is the digital front end of a four-channel digital-to-analog converter. A host talks to it as an SPI slave over a chip select, a serial clock and one data line in each direction. Every transaction is a 24-bit word. The block decodes that word into three fields: a read flag, a five-bit register address and a 16-bit payload. It keeps the resulting register contents, and presents them in parallel to the analog and power sections that sit around it. Those sections are not part of this block.

Writes and reads use separate address maps. Each channel has four write targets: its code, its gain trim, its offset trim and its control port. A control-port write carries a three-bit selector in its payload. That selector picks which control word receives the remaining 13 bits. Two of these control words are per channel (slew and output control). Two are shared by all channels (main and converter-supply control).

A read takes two frames. The first frame names the register and has the read flag set. The value of that register is then shifted out on MISO during the following frame. By convention the following frame is the no-op word 0x1CE000.

The SPI pins are oversampled by the system clock. The serial clock must therefore stay high and low for at least four system clocks each.

Top module: `dac_spi_regs`

## Requirements
- R1: After a synchronous reset, every stored register reads as zero and MISO is low.
- R2: Frames are shifted in MSB first and MOSI is sampled on the rising SCLK edge. In the frame, bit 23 is the read flag, bits 20:16 are the address and bits 15:0 are the payload. A frame takes effect only when chip select rises.
- R3: A frame with fewer or more than 24 SCLK rising edges is discarded. It changes no register and requests no read.
- R4: On a write, addresses 0x00-0x03 set the channel code, 0x08-0x0B the gain and 0x10-0x13 the offset, and 0x1C-0x1F address the channel control port. The low two address bits select the channel. All other write addresses change nothing.
- R5: On a control-port write, payload bits 15:13 select the target and bits 12:0 are the value. Selector 0 writes the channel slew word, 1 the shared main word, 2 the channel output-control word and 3 the shared supply word. Selectors 4 to 7 store nothing.
- R6: The read addresses are as follows. 0x00-0x03 return the code, 0x04-0x07 the output-control word, 0x08-0x0B the gain, 0x0C-0x0F the offset and 0x14-0x17 the slew word. 0x19 returns the main word and 0x1A the supply word. The 13-bit control words are zero-extended.
- R7: The value requested by a read is shifted out MSB first in bits 15:0 of the next frame, and bits 23:16 of that frame are zero. MISO changes only after a falling SCLK edge.
- R8: MISO is zero throughout any frame that follows a frame without a valid read. A pending read is consumed by exactly one frame.
- R9: The no-op word 0x1CE000 changes no register.
- R10: A frame carrying the read flag changes no register.
- R11: A read of a clear-code address (0x10-0x13), of the status address 0x18 or of 0x1B-0x1F returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| dac_code_o | output | 64 | Channel codes, channel n in bits 16n+15:16n |
| gain_o | output | 64 | Channel gain trims, same packing |
| offset_o | output | 64 | Channel offset trims, same packing |
| slew_o | output | 52 | Channel slew words, channel n in bits 13n+12:13n |
| dac_ctrl_o | output | 52 | Channel output-control words, same packing |
| main_ctrl_o | output | 13 | Shared main control word |
| dcdc_ctrl_o | output | 13 | Shared supply control word |

## Verification
A wrong decode of address or selector shows up on the parallel outputs a few system clocks after chip select rises, because the wrong word changes or the right one stays put. A bad read mux or a stale pending read shows up only one frame later, as a wrong value in the low 16 bits shifted out on MISO. So every read is followed by a frame whose received bits are compared. Frames of bad length, the no-op word and read frames are each followed by a full comparison of all outputs, so that a stray write is seen at once.

// File: rtl/dac_spi_pkg.sv
// Shared constants and types for the four-channel DAC serial register block.
// Assumes: the register map is fixed at four channels (two address bits).
package dac_spi_pkg;
    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 5;
    localparam int WORD_W  = 16;
    localparam int CTL_W   = 13;
    localparam int CH_BITS = 2;
    localparam int NCH     = 1 << CH_BITS;
    localparam int GRP_W   = ADDR_W - CH_BITS;
    localparam int SEL_W   = WORD_W - CTL_W;
    localparam int RD_FLAG_BIT = FRAME_W - 1;

    // Write groups, upper three address bits.
    localparam logic [GRP_W-1:0] WG_CODE   = 3'b000;
    localparam logic [GRP_W-1:0] WG_GAIN   = 3'b010;
    localparam logic [GRP_W-1:0] WG_OFFSET = 3'b100;
    localparam logic [GRP_W-1:0] WG_CTRL   = 3'b111;

    // Read groups, upper three address bits.
    localparam logic [GRP_W-1:0] RG_CODE   = 3'b000;
    localparam logic [GRP_W-1:0] RG_OUTCTL = 3'b001;
    localparam logic [GRP_W-1:0] RG_GAIN   = 3'b010;
    localparam logic [GRP_W-1:0] RG_OFFSET = 3'b011;
    localparam logic [GRP_W-1:0] RG_SLEW   = 3'b101;
    localparam logic [GRP_W-1:0] RG_SHARED = 3'b110;

    // Control-port target selector carried in payload bits 15:13.
    typedef enum logic [2:0] {
        SEL_SLEW   = 3'd0,
        SEL_MAIN   = 3'd1,
        SEL_OUTCTL = 3'd2,
        SEL_SUPPLY = 3'd3,
        SEL_SOFT   = 3'd4
    } ctl_sel_e;
endpackage

// File: rtl/spi_frame_port.sv
// SPI slave framing for 24-bit words, oversampled by the system clock.
// Does: synchronises the pins, shifts MOSI in on rising SCLK, counts bits,
// issues a one-cycle commit when chip select rises after exactly FRAME_W bits,
// and shifts a pending read value out on MISO during the following frame.
// Assumes: SCLK idles low; each SCLK phase lasts more than SYNC_STAGES+1 clocks.
module spi_frame_port #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_W     = 24,
    parameter int RD_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [RD_W-1:0]    rd_data,
    output logic               miso,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_SAT = FRAME_W + 1;
    localparam int PAD_W   = FRAME_W - RD_W;

    logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
    logic                   sclk_q, cs_q;
    logic                   sclk_s, cs_s, mosi_s;
    logic                   sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [FRAME_W-1:0]     rx_sr, tx_sr;
    logic [RD_W-1:0]        tx_next;

    assign sclk_s = sclk_sy[SYNC_STAGES-1];
    assign cs_s   = cs_sy[SYNC_STAGES-1];
    assign mosi_s = mosi_sy[SYNC_STAGES-1];

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = cs_s & ~cs_q;
    assign cs_fall   = ~cs_s & cs_q;
    assign miso      = tx_sr[FRAME_W-1];

    // Bring the three SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            cs_sy   <= '1;
            mosi_sy <= '0;
        end else begin
            sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
            cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
            mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
        end
    end

    // Keep last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    // Shift in MOSI and count rising edges, saturating one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (!cs_s && sclk_rise) begin
            rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
            if (bit_cnt != CNT_W'(CNT_SAT))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Commit the frame on chip-select release when the length is exact.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (cs_rise && bit_cnt == CNT_W'(FRAME_W)) begin
                frame_vld <= 1'b1;
                frame     <= rx_sr;
            end
        end
    end

    // Capture requested read data at commit; hand it to the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_next <= '0;
        end else if (cs_fall) begin
            tx_next <= '0;
        end else if (frame_vld) begin
            tx_next <= frame[FRAME_W-1] ? rd_data : '0;
        end
    end

    // Output shifter: load at frame start, advance on falling SCLK, clear at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (cs_fall) begin
            tx_sr <= {{PAD_W{1'b0}}, tx_next};
        end else if (cs_rise) begin
            tx_sr <= '0;
        end else if (!cs_s && sclk_fall) begin
            tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/dac_reg_bank.sv
// Register storage and address decoding for four DAC channels.
// Does: applies committed write frames through the write map and the control
// sub-selector, and presents the read map as a combinational word for the
// address held in the committed frame.
// Assumes: frame is stable while frame_vld is low; frame_vld is one cycle.
module dac_reg_bank
    import dac_spi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_vld,
    input  logic [FRAME_W-1:0]      frame,
    output logic [WORD_W-1:0]       rd_data,
    output logic [NCH*WORD_W-1:0]   dac_code_o,
    output logic [NCH*WORD_W-1:0]   gain_o,
    output logic [NCH*WORD_W-1:0]   offset_o,
    output logic [NCH*CTL_W-1:0]    slew_o,
    output logic [NCH*CTL_W-1:0]    dac_ctrl_o,
    output logic [CTL_W-1:0]        main_ctrl_o,
    output logic [CTL_W-1:0]        dcdc_ctrl_o
);
    localparam int XT_W = WORD_W - CTL_W;

    logic                 wr_en;
    logic [GRP_W-1:0]     grp;
    logic [CH_BITS-1:0]   ch;
    logic [SEL_W-1:0]     sel;
    logic [WORD_W-1:0]    wdat;
    logic [CTL_W-1:0]     cval;
    logic                 unused_spare;

    logic [WORD_W-1:0] code_q [NCH];
    logic [WORD_W-1:0] gain_q [NCH];
    logic [WORD_W-1:0] offs_q [NCH];
    logic [CTL_W-1:0]  slew_q [NCH];
    logic [CTL_W-1:0]  octl_q [NCH];
    logic [CTL_W-1:0]  main_q, supply_q;

    assign wr_en = frame_vld & ~frame[RD_FLAG_BIT];
    assign grp   = frame[WORD_W+ADDR_W-1 -: GRP_W];
    assign ch    = frame[WORD_W +: CH_BITS];
    assign wdat  = frame[WORD_W-1:0];
    assign sel   = wdat[WORD_W-1 -: SEL_W];
    assign cval  = wdat[CTL_W-1:0];
    assign unused_spare = ^frame[FRAME_W-2:WORD_W+ADDR_W];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Per-channel words updated by writes aimed at this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[c] <= '0;
                gain_q[c] <= '0;
                offs_q[c] <= '0;
                slew_q[c] <= '0;
                octl_q[c] <= '0;
            end else if (wr_en && ch == CH_BITS'(c)) begin
                case (grp)
                    WG_CODE:   code_q[c] <= wdat;
                    WG_GAIN:   gain_q[c] <= wdat;
                    WG_OFFSET: offs_q[c] <= wdat;
                    WG_CTRL: begin
                        if (sel == SEL_SLEW)   slew_q[c] <= cval;
                        if (sel == SEL_OUTCTL) octl_q[c] <= cval;
                    end
                    default: ;
                endcase
            end
        end

        assign dac_code_o[c*WORD_W +: WORD_W] = code_q[c];
        assign gain_o[c*WORD_W +: WORD_W]     = gain_q[c];
        assign offset_o[c*WORD_W +: WORD_W]   = offs_q[c];
        assign slew_o[c*CTL_W +: CTL_W]       = slew_q[c];
        assign dac_ctrl_o[c*CTL_W +: CTL_W]   = octl_q[c];
    end

    // Shared control words reached through any channel's control port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q   <= '0;
            supply_q <= '0;
        end else if (wr_en && grp == WG_CTRL) begin
            if (sel == SEL_MAIN)   main_q   <= cval;
            if (sel == SEL_SUPPLY) supply_q <= cval;
        end
    end

    assign main_ctrl_o = main_q;
    assign dcdc_ctrl_o = supply_q;

    // Read map for the address in the committed frame; unmapped reads are zero.
    always_comb begin
        rd_data = '0;
        case (grp)
            RG_CODE:   rd_data = code_q[ch];
            RG_OUTCTL: rd_data = {{XT_W{1'b0}}, octl_q[ch]};
            RG_GAIN:   rd_data = gain_q[ch];
            RG_OFFSET: rd_data = offs_q[ch];
            RG_SLEW:   rd_data = {{XT_W{1'b0}}, slew_q[ch]};
            RG_SHARED: begin
                if (ch == CH_BITS'(1)) rd_data = {{XT_W{1'b0}}, main_q};
                if (ch == CH_BITS'(2)) rd_data = {{XT_W{1'b0}}, supply_q};
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dac_spi_regs.sv
// Top of the four-channel DAC serial register interface.
// Does: joins the SPI framing port to the register bank.
// Assumes: clk oversamples SCLK; reset is synchronous and active low.
module dac_spi_regs
    import dac_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  miso,
    output logic [NCH*WORD_W-1:0] dac_code_o,
    output logic [NCH*WORD_W-1:0] gain_o,
    output logic [NCH*WORD_W-1:0] offset_o,
    output logic [NCH*CTL_W-1:0]  slew_o,
    output logic [NCH*CTL_W-1:0]  dac_ctrl_o,
    output logic [CTL_W-1:0]      main_ctrl_o,
    output logic [CTL_W-1:0]      dcdc_ctrl_o
);
    logic               frame_vld;
    logic [FRAME_W-1:0] frame;
    logic [WORD_W-1:0]  rd_data;

    spi_frame_port #(
        .SYNC_STAGES(SYNC_STAGES),
        .FRAME_W    (FRAME_W),
        .RD_W       (WORD_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .rd_data  (rd_data),
        .miso     (miso),
        .frame_vld(frame_vld),
        .frame    (frame)
    );

    dac_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame      (frame),
        .rd_data    (rd_data),
        .dac_code_o (dac_code_o),
        .gain_o     (gain_o),
        .offset_o   (offset_o),
        .slew_o     (slew_o),
        .dac_ctrl_o (dac_ctrl_o),
        .main_ctrl_o(main_ctrl_o),
        .dcdc_ctrl_o(dcdc_ctrl_o)
    );
endmodule

// File: rtl/dac_spi_regs_chk.sv
// Assertion checker for dac_spi_regs, attached with bind.
// Does: checks reset state, that storage moves only on qualifying commits,
// and the MISO timing and idle level.
module dac_spi_regs_chk #(
    parameter int REGS_W  = 322,
    parameter int FRAME_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               cs_n,
    input logic               miso,
    input logic               frame_vld,
    input logic [FRAME_W-1:0] frame,
    input logic [REGS_W-1:0]  regs
);
    logic rst_seen_q = 1'b0;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: state right after a reset edge is all zero.
    always @(posedge clk) begin
        if (rst_seen_q)
            assert_reset_zero_R1: assert (regs == '0 && miso == 1'b0)
                else $error("R1 state not cleared by reset");
    end

    // R3: without a committed frame no stored word may move.
    assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(regs));

    // R10: a read frame leaves storage untouched.
    assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame[FRAME_W-1]) |=> $stable(regs));

    // R9: the no-op word leaves storage untouched.
    assert_noop_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && frame == 24'h1CE000) |=> $stable(regs));

    // R4: writes into the unused group 0x04-0x07 change nothing.
    assert_write_hole_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !frame[FRAME_W-1] && frame[20:18] == 3'b001) |=> $stable(regs));

    // R7: MISO does not move while SCLK stays high.
    assert_miso_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && !cs_n) |-> $stable(miso));

    // R8: MISO is low once chip select has been high for a few cycles.
    assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);
endmodule

bind dac_spi_regs dac_spi_regs_chk #(
    .REGS_W (322),
    .FRAME_W(24)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .miso     (miso),
    .frame_vld(frame_vld),
    .frame    (frame),
    .regs     ({dac_code_o, gain_o, offset_o, slew_o, dac_ctrl_o, main_ctrl_o, dcdc_ctrl_o})
);

// File: tb/sim_dac_spi_regs.sv
// Self-checking bench for dac_spi_regs: directed corners plus seeded random frames.
module sim_dac_spi_regs;
    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [63:0] dac_code_o, gain_o, offset_o;
    logic [51:0] slew_o, dac_ctrl_o;
    logic [12:0] main_ctrl_o, dcdc_ctrl_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_code [4];
    logic [15:0] m_gain [4];
    logic [15:0] m_offs [4];
    logic [12:0] m_slew [4];
    logic [12:0] m_octl [4];
    logic [12:0] m_main, m_supply;
    logic [15:0] m_pend;

    always #5 clk = ~clk;

    dac_spi_regs u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .dac_code_o(dac_code_o), .gain_o(gain_o),
        .offset_o(offset_o), .slew_o(slew_o), .dac_ctrl_o(dac_ctrl_o),
        .main_ctrl_o(main_ctrl_o), .dcdc_ctrl_o(dcdc_ctrl_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        logic [1:0] c = a[1:0];
        case (a[4:2])
            3'b000: return m_code[c];
            3'b001: return {3'b0, m_octl[c]};
            3'b010: return m_gain[c];
            3'b011: return m_offs[c];
            3'b101: return {3'b0, m_slew[c]};
            3'b110: return (c == 2'd1) ? {3'b0, m_main} : (c == 2'd2) ? {3'b0, m_supply} : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input logic [23:0] w);
        logic [1:0]  c = w[17:16];
        logic [12:0] v = w[12:0];
        case (w[20:18])
            3'b000: m_code[c] = w[15:0];
            3'b010: m_gain[c] = w[15:0];
            3'b100: m_offs[c] = w[15:0];
            3'b111: case (w[15:13])
                3'd0: m_slew[c] = v;
                3'd1: m_main = v;
                3'd2: m_octl[c] = v;
                3'd3: m_supply = v;
                default: ;
            endcase
            default: ;
        endcase
    endtask

    function automatic logic [63:0] pack16(input logic [15:0] a0, a1, a2, a3);
        return {a3, a2, a1, a0};
    endfunction

    function automatic logic [63:0] pack13(input logic [12:0] a0, a1, a2, a3);
        return {12'h0, a3, a2, a1, a0};
    endfunction

    task automatic chk_regs(input string req);
        chk({req, " code"},   dac_code_o, pack16(m_code[0], m_code[1], m_code[2], m_code[3]));
        chk({req, " gain"},   gain_o,     pack16(m_gain[0], m_gain[1], m_gain[2], m_gain[3]));
        chk({req, " offset"}, offset_o,   pack16(m_offs[0], m_offs[1], m_offs[2], m_offs[3]));
        chk({req, " slew"},   {12'h0, slew_o},     pack13(m_slew[0], m_slew[1], m_slew[2], m_slew[3]));
        chk({req, " outctl"}, {12'h0, dac_ctrl_o}, pack13(m_octl[0], m_octl[1], m_octl[2], m_octl[3]));
        chk({req, " shared"}, {38'h0, main_ctrl_o, dcdc_ctrl_o}, {38'h0, m_main, m_supply});
    endtask

    // Drive one frame of nbits bits; capture the first 24 MISO bits.
    task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'($urandom);
            repeat (HP) @(negedge clk);
            if (i < 24) got = {got[22:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    // One frame against the model: readback check, model update, output check.
    task automatic frame(input logic [23:0] w, input int nbits, input string req);
        logic [23:0] got;
        xfer(w, nbits, got);
        if (nbits >= 24) chk("R7 R8 readback", {40'h0, got}, {48'h0, m_pend});
        m_pend = 16'h0;
        if (nbits == 24) begin
            if (w[23]) m_pend = exp_rd(w[20:16]);
            else model_write(w);
        end
        chk_regs(req);
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        logic [23:0] got;
        frame({1'b1, 2'b0, a, 16'h0}, 24, "R10 read frame");
        xfer(24'h1CE000, 24, got);
        chk(req, {40'h0, got}, {48'h0, m_pend});
        m_pend = 16'h0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7301));
        for (int c = 0; c < 4; c++) begin
            m_code[c] = 0; m_gain[c] = 0; m_offs[c] = 0; m_slew[c] = 0; m_octl[c] = 0;
        end
        m_main = 0; m_supply = 0; m_pend = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_regs("R1 reset");
        chk("R1 miso after reset", {63'h0, miso}, 64'h0);

        // R2 R4 writes and readback.
        frame(24'h02A5C3, 24, "R2 R4 code write");
        frame(24'h0B1234, 24, "R4 gain write");
        frame(24'h10BEEF, 24, "R4 offset write");
        frame(24'h05FFFF, 24, "R4 hole write");
        frame(24'h18FFFF, 24, "R4 unmapped write");
        rd(5'h02, "R6 code readback");
        rd(5'h0B, "R6 gain readback");
        rd(5'h0C, "R6 offset readback");

        // R5 control-port sub-selector.
        frame({8'h1D, 3'd0, 13'h1ABC}, 24, "R5 slew sel");
        frame({8'h1F, 3'd1, 13'h0155}, 24, "R5 main sel");
        frame({8'h1C, 3'd2, 13'h1F0F}, 24, "R5 outctl sel");
        frame({8'h1E, 3'd3, 13'h007F}, 24, "R5 supply sel");
        frame({8'h1D, 3'd4, 13'h1FFF}, 24, "R5 soft sel");
        frame({8'h1E, 3'd6, 13'h1FFF}, 24, "R5 spare sel");
        rd(5'h15, "R6 slew readback");
        rd(5'h19, "R6 main readback");
        rd(5'h04, "R6 outctl readback");
        rd(5'h1A, "R6 supply readback");

        // R3 bad lengths.
        frame(24'h03FFFF, 23, "R3 short frame");
        frame(24'h03FFFF, 25, "R3 long frame");
        frame(24'h83FFFF, 20, "R3 short read");

        // R11 unmapped reads.
        rd(5'h11, "R11 clear code read");
        rd(5'h18, "R11 status read");
        rd(5'h1B, "R11 top read");

        // R8 R9 noop alone, pending consumed by a short frame.
        frame(24'h1CE000, 24, "R9 noop");
        frame(24'h820000, 24, "R10 read frame");
        frame(24'h1CE000, 22, "R8 consume short");
        frame(24'h1CE000, 24, "R8 after consume");

        for (int n = 0; n < 150; n++) begin
            int          kind = $urandom_range(0, 9);
            int          nb = 24;
            logic [23:0] w = {3'b0, 5'($urandom), 16'($urandom)};
            if (kind < 3) w[23] = 1'b1;
            if (kind == 9) nb = ($urandom_range(0, 1) == 1) ? 27 : 19;
            frame(w, nb, "R2 R3 R4 R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule